// File: doc/BRIEF.md
# Data-Ready Frame Capture and Sample Unpacker

This block sits between a multi-channel delta-sigma converter and the on-chip consumers of its samples. It watches the converter's active-low data-ready line and requests a frame read whenever that line falls. It drives a shared byte-wide serial shifter, which the command path also uses, to send the START, STOP and read-data opcodes and to clock in the frame. It then splits the frame into per-channel samples. Each enabled channel leaves as a 32-bit word on a valid/ready stream.

Two operating modes exist. While `streamEn` is high the converter runs freely: START goes out when streaming is switched on, and STOP goes out when it is switched off. With streaming off, a `shotReq` pulse runs one acquisition. The block sends START, waits a bounded time for data-ready, reads and emits the frame, then sends STOP. If data-ready never comes, the block reports a timeout instead.

The per-channel sample width depends on the converter's output rate. Samples are 16 bits at the two fastest rates and 24 bits otherwise. Both widths come out in the same left-aligned, sign-correct 24-in-32 container.

Top module: `frame_capture_unpacker`

## Requirements
- R1: A low-to-high change of `streamEn` causes the next command byte sent to be START (0x08). A high-to-low change causes STOP (0x0A) to be sent once any frame in progress has been emitted.
- R2: While streaming, each falling edge of `drdyN` is seen after a two-flop synchroniser and sends the read-data opcode 0x12. It is followed by exactly 3 + B×NUM_CH read transfers that send 0x00. `spiReq` and `spiTx` hold steady until `spiAck`.
- R3: B, the number of bytes per channel, is 2 when `rateFast` is 1 and 3 when it is 0. `rateFast` is sampled when the frame begins.
- R4: With B = 3, channel c occupies frame bytes 3+3c, 4+3c and 5+3c, most significant first. Its output word is {byte0, byte1, byte2, 8'h00}.
- R5: With B = 2, channel c occupies frame bytes 3+2c and 4+2c. Its output word is {fill, byte0, byte1, 8'h00}, where fill is 8'hFF if bit 7 of byte0 is set and 8'h00 otherwise.
- R6: Only channels whose bit is set in `chanMask` (bit c for channel c) are emitted. They go out in ascending channel order with no gaps, and `outLast` is set on the highest enabled channel. An all-zero mask emits nothing. The mask is sampled when the frame begins.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` hold.
- R8: With `streamEn` low, a `shotReq` pulse sends START and waits for a data-ready edge. It then reads the frame, emits the enabled words, and sends STOP.
- R9: In single-shot mode, if no data-ready edge arrives within TIMEOUT_CYCLES of START completing, the block pulses `timeoutErr` for one cycle, sends STOP, and emits no words.
- R10: A data-ready edge that arrives between the start of a frame and the end of its emission pulses `overrunErr` for one cycle. It starts no further frame read.
- R11: After reset, `spiReq`, `outValid`, `timeoutErr` and `overrunErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| streamEn | input | 1 | Level: continuous conversion requested |
| shotReq | input | 1 | Pulse: one single-shot acquisition (ignored while streaming) |
| rateFast | input | 1 | 1 selects 2-byte samples, 0 selects 3-byte samples |
| chanMask | input | NUM_CH | Channel enable mask, bit c = channel c |
| drdyN | input | 1 | Asynchronous active-low data-ready from the converter |
| spiReq | output | 1 | Byte transfer request to the shared shifter |
| spiTx | output | 8 | Byte to send during the requested transfer |
| spiAck | input | 1 | One-cycle pulse: requested transfer finished |
| spiRx | input | 8 | Byte received, valid with `spiAck` |
| outValid | output | 1 | Sample word valid |
| outReady | input | 1 | Consumer accepts the word |
| outData | output | 32 | Sample, left-aligned 24 bits, low byte zero |
| outLast | output | 1 | Word is the last enabled channel of its frame |
| timeoutErr | output | 1 | One-cycle pulse: single-shot data-ready timeout |
| overrunErr | output | 1 | One-cycle pulse: data-ready edge during a frame |

## Verification
The unpacker is exercised with every one of the 16 channel masks at both sample widths on a four-channel configuration. The frame bytes are generated so that sample most-significant bits are mixed, which separates sign fill from zero fill and shows channel offsets that are off by one byte. Half of the frames run with a consumer that stalls, which exposes words that are dropped or duplicated under back-pressure.

Further runs change the mask in the middle of a frame, send a second data-ready edge during a read, and make single-shot requests both with and without a data-ready edge. Each of these checks the logged command bytes as well as the emitted words.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  localparam logic [7:0] OP_START = 8'h08;
  localparam logic [7:0] OP_STOP  = 8'h0A;
  localparam logic [7:0] OP_RDATA = 8'h12;
  localparam logic [7:0] OP_FILL  = 8'h00;
  localparam int STATUS_BYTES = 3;

  typedef struct packed {
    logic frameStart;  // frame begins: sample mask and width
    logic capStb;      // store one data byte
    logic emitStart;   // all bytes stored, start emission
  } ctrlStb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LISTEN, S_WAIT, S_SEND, S_READ, S_EMIT
  } ctrlState_t;
endpackage

// File: rtl/fcap_ctrl.sv
module fcap_ctrl
  import fcap_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W = 3,
  parameter int TIMEOUT_CYCLES = 300000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            streamEn,
  input  logic            shotReq,
  input  logic            rateFast,
  input  logic            drdyFall,
  input  logic            emitDone,
  input  logic            spiAck,
  output logic            spiReq,
  output logic [7:0]      spiTx,
  output logic            timeoutErr,
  output logic            overrunErr,
  output ctrlStb_t        stb,
  output logic [CH_W-1:0] capChan,
  output logic [1:0]      capPos,
  output logic            narrowSel
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  ctrlState_t state, retState;
  logic [7:0]      cmdQ;
  logic            oneShotQ, frameBusy, fastQ;
  logic [1:0]      statLeft, posQ;
  logic [CH_W-1:0] chanQ;
  logic [TW-1:0]   tmr;
  logic            lastPos, lastChan;

  assign lastPos  = fastQ ? (posQ == 2'd1) : (posQ == 2'd2);
  assign lastChan = (chanQ == CH_W'(NUM_CH - 1));

  assign spiReq = (state == S_SEND) || (state == S_READ);
  assign spiTx  = (state == S_SEND) ? cmdQ : OP_FILL;

  always_comb begin
    stb.frameStart = drdyFall && ((state == S_LISTEN && streamEn) || state == S_WAIT);
    stb.capStb     = (state == S_READ) && spiAck && (statLeft == 2'd0);
    stb.emitStart  = stb.capStb && lastPos && lastChan;
  end

  assign capChan   = chanQ;
  assign capPos    = posQ;
  assign narrowSel = fastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      retState   <= S_IDLE;
      cmdQ       <= OP_FILL;
      oneShotQ   <= 1'b0;
      frameBusy  <= 1'b0;
      fastQ      <= 1'b0;
      statLeft   <= 2'd0;
      posQ       <= 2'd0;
      chanQ      <= '0;
      tmr        <= '0;
      timeoutErr <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      timeoutErr <= 1'b0;
      overrunErr <= drdyFall && frameBusy;
      if (stb.frameStart) begin
        frameBusy <= 1'b1;
        fastQ     <= rateFast;
        statLeft  <= 2'(STATUS_BYTES);
        chanQ     <= '0;
        posQ      <= 2'd0;
        cmdQ      <= OP_RDATA;
        retState  <= S_READ;
        state     <= S_SEND;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (streamEn) begin
              cmdQ <= OP_START; retState <= S_LISTEN; oneShotQ <= 1'b0; state <= S_SEND;
            end else if (shotReq) begin
              cmdQ <= OP_START; retState <= S_WAIT; oneShotQ <= 1'b1; tmr <= '0; state <= S_SEND;
            end
          end
          S_LISTEN: begin
            if (!streamEn) begin
              cmdQ <= OP_STOP; retState <= S_IDLE; state <= S_SEND;
            end
          end
          S_WAIT: begin
            if (tmr == TW'(TIMEOUT_CYCLES - 1)) begin
              timeoutErr <= 1'b1;
              cmdQ <= OP_STOP; retState <= S_IDLE; state <= S_SEND;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          S_SEND: if (spiAck) state <= retState;
          S_READ: begin
            if (spiAck) begin
              if (statLeft != 2'd0) begin
                statLeft <= statLeft - 1'b1;
              end else if (lastPos) begin
                posQ <= 2'd0;
                if (lastChan) state <= S_EMIT;
                else chanQ <= chanQ + 1'b1;
              end else begin
                posQ <= posQ + 1'b1;
              end
            end
          end
          S_EMIT: begin
            if (emitDone) begin
              frameBusy <= 1'b0;
              if (oneShotQ) begin
                cmdQ <= OP_STOP; retState <= S_IDLE; state <= S_SEND;
              end else begin
                state <= S_LISTEN;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiReq && !spiAck |=> spiReq && $stable(spiTx));
  // R9
  tmo_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> spiReq && spiTx == OP_STOP);
  // R10
  overrun_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |-> $past(state != S_LISTEN && state != S_WAIT && state != S_IDLE));
endmodule

// File: rtl/fcap_datapath.sv
module fcap_datapath
  import fcap_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drdyN,
  input  logic [NUM_CH-1:0] chanMask,
  input  ctrlStb_t          stb,
  input  logic [CH_W-1:0]   capChan,
  input  logic [1:0]        capPos,
  input  logic              narrowSel,
  input  logic [7:0]        capByte,
  input  logic              outReady,
  output logic              drdyFall,
  output logic              emitDone,
  output logic              outValid,
  output logic [31:0]       outData,
  output logic              outLast
);
  localparam int SLOTS = 1 << CH_W;
  localparam int PW = CH_W + 1;

  logic [2:0]       drdySh;
  logic [SLOTS-1:0] maskQ;
  logic [23:0]      samp [SLOTS];
  logic             emitting;
  logic [PW-1:0]    ptr;
  logic [CH_W-1:0]  chIdx;
  logic             inRange;

  // two synchroniser flops, third flop for the edge
  always_ff @(posedge clk) begin
    if (!rstN) drdySh <= 3'b111;
    else       drdySh <= {drdySh[1:0], drdyN};
  end
  assign drdyFall = drdySh[2] && !drdySh[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      for (int i = 0; i < SLOTS; i++) samp[i] <= '0;
    end else begin
      if (stb.frameStart) maskQ <= SLOTS'(chanMask);
      if (stb.capStb) begin
        if (narrowSel) begin
          if (capPos == 2'd0) samp[capChan][23:8] <= {{8{capByte[7]}}, capByte};
          else                samp[capChan][7:0]  <= capByte;
        end else begin
          unique case (capPos)
            2'd0:    samp[capChan][23:16] <= capByte;
            2'd1:    samp[capChan][15:8]  <= capByte;
            default: samp[capChan][7:0]   <= capByte;
          endcase
        end
      end
    end
  end

  assign chIdx    = ptr[CH_W-1:0];
  assign inRange  = ptr < PW'(NUM_CH);
  assign outValid = emitting && inRange && maskQ[chIdx];
  assign emitDone = emitting && !inRange;
  assign outData  = {samp[chIdx], 8'h00};

  always_comb begin
    outLast = outValid;
    for (int i = 0; i < SLOTS; i++)
      if (i > int'(chIdx) && maskQ[i]) outLast = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emitting <= 1'b0;
      ptr      <= '0;
    end else if (stb.emitStart) begin
      emitting <= 1'b1;
      ptr      <= '0;
    end else if (emitting) begin
      if (!inRange)                          emitting <= 1'b0;
      else if (!maskQ[chIdx] || outReady)    ptr <= ptr + 1'b1;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));
  // R6
  last_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid);
  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
endmodule

// File: rtl/frame_capture_unpacker.sv
module frame_capture_unpacker
  import fcap_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TIMEOUT_CYCLES = 300000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              streamEn,
  input  logic              shotReq,
  input  logic              rateFast,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              drdyN,
  output logic              spiReq,
  output logic [7:0]        spiTx,
  input  logic              spiAck,
  input  logic [7:0]        spiRx,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outData,
  output logic              outLast,
  output logic              timeoutErr,
  output logic              overrunErr
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  ctrlStb_t        stb;
  logic            drdyFall, emitDone, narrowSel;
  logic [CH_W-1:0] capChan;
  logic [1:0]      capPos;

  fcap_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk, .rstN, .streamEn, .shotReq, .rateFast, .drdyFall, .emitDone, .spiAck,
    .spiReq, .spiTx, .timeoutErr, .overrunErr, .stb, .capChan, .capPos, .narrowSel
  );

  fcap_datapath #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dp (
    .clk, .rstN, .drdyN, .chanMask, .stb, .capChan, .capPos, .narrowSel,
    .capByte(spiRx), .outReady, .drdyFall, .emitDone, .outValid, .outData, .outLast
  );
endmodule

// File: tb/frame_capture_unpacker_bench.sv
module frame_capture_unpacker_bench;
  localparam int NCH = 4;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic streamEn = 1'b0, shotReq = 1'b0, rateFast = 1'b0;
  logic [NCH-1:0] chanMask = '0;
  logic drdyN = 1'b1;
  logic spiReq, spiAck = 1'b0;
  logic [7:0] spiTx, spiRx = 8'h00;
  logic outValid, outReady = 1'b1, outLast, timeoutErr, overrunErr;
  logic [31:0] outData;

  always #10 clk = ~clk;

  frame_capture_unpacker #(.NUM_CH(NCH), .TIMEOUT_CYCLES(TMO)) u_frame_capture_unpacker (
    .clk, .rstN, .streamEn, .shotReq, .rateFast, .chanMask, .drdyN,
    .spiReq, .spiTx, .spiAck, .spiRx, .outValid, .outReady, .outData, .outLast,
    .timeoutErr, .overrunErr
  );

  int total = 0, fails = 0;
  int curSeed = 0, rdPtr = 0;
  logic [7:0] txLog [0:2047];
  int txCnt = 0;
  logic [31:0] rxWords [0:63];
  logic rxLast [0:63];
  int rxCnt = 0;
  int ovCnt = 0, tmoCnt = 0;
  bit stallOn = 1'b0;
  int cyc = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] fb(int seed, int k);
    return 8'((seed * 53 + k * 29 + 7) ^ (k * k * 3));
  endfunction

  function automatic logic [31:0] expWord(int seed, int ch, bit fast);
    int off;
    logic [7:0] b0, b1, b2;
    off = fast ? 3 + ch * 2 : 3 + ch * 3;
    b0 = fb(seed, off); b1 = fb(seed, off + 1); b2 = fb(seed, off + 2);
    return fast ? {{8{b0[7]}}, b0, b1, 8'h00} : {b0, b1, b2, 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // shared shifter model
  initial begin
    forever begin
      @(negedge clk);
      if (spiReq && rstN) begin
        logic [7:0] b;
        b = spiTx;
        txLog[txCnt % 2048] = b;
        txCnt++;
        if (b == 8'h12) rdPtr = 0;
        repeat (2) @(negedge clk);
        if (b == 8'h00) begin spiRx = fb(curSeed, rdPtr); rdPtr++; end
        else spiRx = 8'h00;
        spiAck = 1'b1;
        @(negedge clk);
        spiAck = 1'b0;
      end
    end
  end

  // sink and pulse monitors
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      outReady = stallOn ? (cyc % 3 != 1) : 1'b1;
      if (outValid && outReady && rxCnt < 64) begin
        rxWords[rxCnt] = outData; rxLast[rxCnt] = outLast; rxCnt++;
      end
      if (overrunErr) ovCnt++;
      if (timeoutErr) tmoCnt++;
    end
  end

  task automatic pulseDrdy();
    @(negedge clk); drdyN = 1'b0;
    repeat (3) @(negedge clk); drdyN = 1'b1;
  endtask

  task automatic checkWords(input int seed, input bit fast, input logic [NCH-1:0] m, input string tag);
    int n = 0;
    for (int c = 0; c < NCH; c++) if (m[c]) n++;
    chk(rxCnt == n, "R6 word count", rxCnt, n);
    n = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m[c] && n < rxCnt) begin
        chk(rxWords[n] == expWord(seed, c, fast), tag, rxWords[n], expWord(seed, c, fast));
        chk(rxLast[n] == ((m >> (c + 1)) == 0), "R6 last flag", rxLast[n], (m >> (c + 1)) == 0);
        n++;
      end
    end
  endtask

  task automatic countTx(input int base, output int nRd, output int nOp);
    nRd = 0; nOp = 0;
    for (int i = base; i < txCnt; i++) begin
      if (txLog[i % 2048] == 8'h00) nRd++;
      if (txLog[i % 2048] == 8'h12) nOp++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int base, nRd, nOp;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(spiReq == 1'b0, "R11 spiReq", spiReq, 0);
    chk(outValid == 1'b0, "R11 outValid", outValid, 0);
    chk(timeoutErr == 1'b0 && overrunErr == 1'b0, "R11 flags", {timeoutErr, overrunErr}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 start on enable
    base = txCnt;
    streamEn = 1'b1;
    repeat (30) @(negedge clk);
    chk(txCnt == base + 1 && txLog[base % 2048] == 8'h08, "R1 START", txLog[base % 2048], 8'h08);

    // R2 R3 R4 R5 R6 R7: sweep masks and widths
    for (int f = 0; f < 2; f++) begin
      for (int m = 0; m < 16; m++) begin
        rateFast = f[0]; chanMask = m[NCH-1:0]; curSeed = f * 16 + m + 1;
        stallOn = m[0]; rxCnt = 0; base = txCnt;
        pulseDrdy();
        rateFast = ~f[0];
        repeat (300) @(negedge clk);
        countTx(base, nRd, nOp);
        chk(txLog[base % 2048] == 8'h12 && nOp == 1, "R2 read opcode", txLog[base % 2048], 8'h12);
        chk(nRd == 3 + (f ? 2 : 3) * NCH, "R3 frame length", nRd, 3 + (f ? 2 : 3) * NCH);
        checkWords(curSeed, f[0], m[NCH-1:0], f ? "R5 narrow word" : "R4 wide word");
      end
    end
    stallOn = 1'b0;

    // R6 mask sampled at frame start
    rateFast = 1'b0; chanMask = 4'b1010; curSeed = 77; rxCnt = 0;
    pulseDrdy();
    repeat (8) @(negedge clk);
    chanMask = 4'b0101;
    repeat (300) @(negedge clk);
    checkWords(77, 1'b0, 4'b1010, "R6 mask latch");

    // R10 overrun
    chanMask = 4'hF; curSeed = 91; rxCnt = 0; base = txCnt; ovCnt = 0;
    pulseDrdy();
    repeat (30) @(negedge clk);
    pulseDrdy();
    repeat (300) @(negedge clk);
    countTx(base, nRd, nOp);
    chk(ovCnt == 1, "R10 overrun pulse", ovCnt, 1);
    chk(nOp == 1, "R10 single read", nOp, 1);
    checkWords(91, 1'b0, 4'hF, "R10 words intact");

    // R1 stop on disable
    base = txCnt;
    streamEn = 1'b0;
    repeat (30) @(negedge clk);
    chk(txCnt == base + 1 && txLog[base % 2048] == 8'h0A, "R1 STOP", txLog[base % 2048], 8'h0A);

    // R8 single shot
    rateFast = 1'b1; chanMask = 4'b0110; curSeed = 123; rxCnt = 0; base = txCnt;
    @(negedge clk); shotReq = 1'b1; @(negedge clk); shotReq = 1'b0;
    repeat (20) @(negedge clk);
    chk(txLog[base % 2048] == 8'h08, "R8 START", txLog[base % 2048], 8'h08);
    pulseDrdy();
    repeat (300) @(negedge clk);
    countTx(base, nRd, nOp);
    chk(nOp == 1 && nRd == 3 + 2 * NCH, "R8 frame read", nRd, 3 + 2 * NCH);
    chk(txLog[(txCnt - 1) % 2048] == 8'h0A, "R8 STOP", txLog[(txCnt - 1) % 2048], 8'h0A);
    checkWords(123, 1'b1, 4'b0110, "R8 words");

    // R9 timeout
    rxCnt = 0; base = txCnt; tmoCnt = 0;
    @(negedge clk); shotReq = 1'b1; @(negedge clk); shotReq = 1'b0;
    repeat (TMO + 100) @(negedge clk);
    chk(tmoCnt == 1, "R9 timeout pulse", tmoCnt, 1);
    chk(txCnt == base + 2 && txLog[base % 2048] == 8'h08 && txLog[(base + 1) % 2048] == 8'h0A,
        "R9 START then STOP", txCnt - base, 2);
    chk(rxCnt == 0, "R9 no words", rxCnt, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule